// File: doc/BRIEF.md
# Fractional clock divider synthesizer

This block derives a slower clock from its own input clock by dividing by twice a fixed-point divisor. The divisor has three integer bits and fourteen fractional bits. Each output half-period is a whole number of input cycles. A fourteen-bit phase accumulator collects the fractional part once per half-period and adds one extra input cycle whenever it wraps. Individual half-periods are therefore uneven, but their long-run average is exact.

Software writes a 32-bit control word. The divider looks only at the low seventeen bits and takes a new value at the next half-period boundary, so a rewrite cannot create a runt pulse. The output is a level that toggles (`clk_div_o`) plus a one-cycle strobe that marks every change of that level. A divisor of zero stops the output and holds it low. The interface carries no data stream, so every pin is a plain control or status pin.

Top module: `fracdiv_synth`

## Requirements
- R1: A synchronous active-high reset clears the control word. It drives `clk_div_o` low and `edge_stb_o` low, and the divider stays idle until a nonzero divisor is written.
- R2: A write stores all 32 bits. `rd_data_o` shows the written word in the cycle after the write edge.
- R3: The divisor is word bits [16:0], read as unsigned 3.14 fixed point: bits [16:14] are the integer part I and bits [13:0] are the fraction F. Bits [31:17] have no effect on the output.
- R4: With I at least 1, half-period k (counted from 0 at start-up) lasts I + floor((k+1)F/2^14) - floor(kF/2^14) input cycles. Every half-period is therefore I or I+1 cycles long.
- R5: Over 2^14 consecutive half-periods from start-up, the total number of input cycles equals the raw 17-bit divisor value. The output frequency is therefore the input frequency divided by twice the divisor.
- R6: With I equal to 0 and F nonzero, every half-period lasts exactly one input cycle.
- R7: A divisor of zero holds `clk_div_o` low with no strobes. If zero is written while the output is running, the output goes low at the next half-period boundary and then stays quiet.
- R8: A divisor written during a half-period leaves that half-period at its old length. The new divisor governs the following half-period.
- R9: `edge_stb_o` is high in exactly those cycles in which `clk_div_o` differs from its value in the previous cycle.
- R10: Start-up from idle: a nonzero write registers at edge k, the divider starts at edge k+1 with the output low, and the output first rises after half-period 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to store |
| rd_data_o | output | 32 | Stored control word |
| clk_div_o | output | 1 | Divided clock level |
| edge_stb_o | output | 1 | One-cycle pulse on each change of `clk_div_o` |

## Verification
A register write and a half-period boundary can land on the same input edge, which raises the question of which divisor the next half-period uses. The bench provokes this by rewriting the divisor one cycle into a running half-period, and also by writing zero while the output is toggling. It judges the outcome by measuring the lengths of the current and following half-periods between strobes. Those lengths are compared with values the bench computes from the old and new divisors.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DIV_W  = 17;
  localparam int unsigned FRAC_W = 14;
  localparam int unsigned INT_W  = DIV_W - FRAC_W;
  localparam int unsigned LEN_W  = INT_W + 1;
endpackage

// File: rtl/fdiv_ctrl_reg.sv
module fdiv_ctrl_reg #(
  parameter int unsigned WORD_W = fdiv_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        word_q <= '0;
    else if (wr_en_i) word_q <= wr_data_i;
  end

  assign word_o = word_q;

  p_readback_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en_i |=> (word_o == $past(wr_data_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(word_o));
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
  parameter int unsigned DIV_W  = fdiv_pkg::DIV_W,
  parameter int unsigned FRAC_W = fdiv_pkg::FRAC_W,
  localparam int unsigned INT_W = DIV_W - FRAC_W,
  localparam int unsigned LEN_W = INT_W + 1
) (
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] phase_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [FRAC_W-1:0] phase_o
);
  logic [INT_W-1:0]  whole;
  logic [FRAC_W-1:0] part;
  logic [FRAC_W:0]   phase_sum;
  logic [LEN_W-1:0]  raw_len;

  always_comb begin
    whole     = div_i[DIV_W-1:FRAC_W];
    part      = div_i[FRAC_W-1:0];
    phase_sum = {1'b0, phase_i} + {1'b0, part};
    raw_len   = {1'b0, whole} + {{(LEN_W-1){1'b0}}, phase_sum[FRAC_W]};
    // a fraction-only divisor still needs one input cycle per half-period
    len_o     = (raw_len == '0) ? LEN_W'(1) : raw_len;
    phase_o   = phase_sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fdiv_gen.sv
module fdiv_gen #(
  parameter int unsigned DIV_W  = fdiv_pkg::DIV_W,
  parameter int unsigned FRAC_W = fdiv_pkg::FRAC_W,
  localparam int unsigned INT_W = DIV_W - FRAC_W,
  localparam int unsigned LEN_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_div_o,
  output logic             edge_stb_o
);
  logic              run_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] phase_q;
  logic              lvl_q;
  logic              stb_q;
  logic [FRAC_W-1:0] phase_in;
  logic [LEN_W-1:0]  len_next;
  logic [FRAC_W-1:0] phase_next;
  logic              div_zero;
  logic              boundary;

  assign div_zero = (div_i == '0);
  assign boundary = run_q && (cnt_q == LEN_W'(1));
  assign phase_in = run_q ? phase_q : '0;

  fdiv_step #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_step (
    .div_i   (div_i),
    .phase_i (phase_in),
    .len_o   (len_next),
    .phase_o (phase_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      phase_q <= '0;
      lvl_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!run_q) begin
        if (!div_zero) begin
          run_q   <= 1'b1;
          cnt_q   <= len_next;
          phase_q <= phase_next;
        end
      end else if (boundary) begin
        if (div_zero) begin
          run_q   <= 1'b0;
          cnt_q   <= '0;
          phase_q <= '0;
          lvl_q   <= 1'b0;
          stb_q   <= lvl_q;
        end else begin
          cnt_q   <= len_next;
          phase_q <= phase_next;
          lvl_q   <= ~lvl_q;
          stb_q   <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

  assign clk_div_o  = lvl_q;
  assign edge_stb_o = stb_q;

  p_stb_on_edge_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_stb_o |-> (clk_div_o != $past(clk_div_o)));
  p_no_silent_edge_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !edge_stb_o |-> $stable(clk_div_o));
  p_idle_low_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_q |-> !clk_div_o);
  p_zero_stops_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (boundary && div_zero) |=> (!run_q && !clk_div_o));
  p_len_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    run_q |-> (cnt_q >= LEN_W'(1) && cnt_q <= LEN_W'(1 << INT_W)));
endmodule

// File: rtl/fracdiv_synth.sv
module fracdiv_synth #(
  parameter int unsigned WORD_W = fdiv_pkg::WORD_W,
  parameter int unsigned DIV_W  = fdiv_pkg::DIV_W,
  parameter int unsigned FRAC_W = fdiv_pkg::FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              clk_div_o,
  output logic              edge_stb_o
);
  logic [WORD_W-1:0] word;

  fdiv_ctrl_reg #(.WORD_W(WORD_W)) u_reg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .word_o    (word)
  );

  fdiv_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_gen (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .div_i      (word[DIV_W-1:0]),
    .clk_div_o  (clk_div_o),
    .edge_stb_o (edge_stb_o)
  );

  assign rd_data_o = word;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!clk_div_o && !edge_stb_o && rd_data_o == '0));
endmodule

// File: tb/fracdiv_synth_tb_top.sv
module fracdiv_synth_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        clk_div;
  logic        edge_stb;
  int nvec = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  fracdiv_synth dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .clk_div_o(clk_div), .edge_stb_o(edge_stb)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data == d, "R2 readback", rd_data, d);
  endtask

  // cycles until the next strobe; also checks that level only moves with a strobe
  task automatic meas(output int n);
    logic prev;
    n = 0;
    prev = clk_div;
    while (1) begin
      @(negedge clk);
      n++;
      if (edge_stb) begin
        if (clk_div == prev) chk(1'b0, "R9 strobe without edge", clk_div, !prev);
        break;
      end
      if (clk_div != prev) begin
        chk(1'b0, "R9 edge without strobe", clk_div, prev);
        prev = clk_div;
      end
      if (n >= 64) begin
        chk(1'b0, "R4 half-period timeout", n, 0);
        break;
      end
    end
  endtask

  function automatic int exp_len(input int ip, input int f, input int k);
    if (ip == 0) return 1;
    return ip + (((k + 1) * f) >> 14) - ((k * f) >> 14);
  endfunction

  task automatic sweep(input int raw, input int nhalf, input bit full);
    int ip, f, n, total;
    string tag;
    ip = raw >> 14;
    f = raw & 16383;
    tag = (ip == 0) ? "R6 fraction-only half-period" : "R4 half-period length";
    do_reset();
    wr(32'(raw));
    meas(n);
    chk(n - 1 == exp_len(ip, f, 0), "R10 first half-period", n - 1, exp_len(ip, f, 0));
    total = n - 1;
    for (int k = 1; k < nhalf; k++) begin
      meas(n);
      chk(n == exp_len(ip, f, k), tag, n, exp_len(ip, f, k));
      total += n;
    end
    if (full) chk(total == raw, "R5 cycles over 2^14 half-periods", total, raw);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    int n, m, hits;
    do_reset();
    chk(clk_div == 1'b0, "R1 output low after reset", clk_div, 0);
    chk(edge_stb == 1'b0, "R1 strobe low after reset", edge_stb, 0);
    chk(rd_data == 32'd0, "R1 word cleared", rd_data, 0);
    hits = 0;
    repeat (20) begin
      @(negedge clk);
      if (clk_div || edge_stb) hits++;
    end
    chk(hits == 0, "R7 zero divisor stays quiet", hits, 0);

    // upper bits set: output must follow the 3.0 divisor only
    do_reset();
    wr(32'hFFFE_C000);
    meas(n);
    chk(n == 4, "R3 start with upper bits set", n, 4);
    for (int i = 0; i < 6; i++) begin
      meas(n);
      chk(n == 3, "R3 upper bits ignored", n, 3);
    end

    // rewrite one cycle into a 4.0 half-period, to 2.0
    do_reset();
    wr(32'h0001_0000);
    meas(n);
    chk(n == 5, "R10 start at 4.0", n, 5);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_8000;
    @(negedge clk);
    wr_en = 1'b0;
    meas(m);
    chk(2 + m == 4, "R8 current half-period keeps old length", 2 + m, 4);
    meas(n);
    chk(n == 2, "R8 next half-period uses new divisor", n, 2);
    meas(n);
    chk(n == 2, "R8 new divisor persists", n, 2);

    // stop while running
    wr(32'd0);
    repeat (4) @(negedge clk);
    hits = 0;
    repeat (30) begin
      @(negedge clk);
      if (clk_div || edge_stb) hits++;
    end
    chk(hits == 0, "R7 stop at boundary then quiet", hits, 0);

    // restart from idle at 1.0
    wr(32'h0000_4000);
    meas(n);
    chk(n == 2, "R10 restart at 1.0", n, 2);
    for (int i = 0; i < 4; i++) begin
      meas(n);
      chk(n == 1, "R4 half-period at 1.0", n, 1);
    end
    rst = 1'b1;
    @(negedge clk);
    chk(clk_div == 1'b0 && rd_data == 32'd0, "R1 reset while running", clk_div, 0);
    rst = 1'b0;

    sweep(32'h6000, 16384, 1'b1);
    sweep(32'h9001, 16384, 1'b1);
    sweep(32'h4001, 512, 1'b0);
    sweep(32'h7FFF, 512, 1'b0);
    sweep(32'h1FFFF, 512, 1'b0);
    sweep(32'h2000, 256, 1'b0);
    sweep(32'h0001, 64, 1'b0);

    report();
    $finish;
  end
endmodule